// File: doc/BRIEF.md
# Message Age Lateness Tagger

This block sits at the injection point of a router or memory-controller node. It holds one header flit at a time on its way into the network. While the flit is held, the block adds the time it spends at this node into a 12-bit age field carried in the header. Each local cycle adds a per-node frequency multiplier, so nodes clocked at different rates add comparable amounts. No global time base is needed. The age field saturates and never wraps.

When the flit is presented for injection, the block compares the age of a response message with a lateness threshold kept for the message's application. If the age is higher, the header priority bit is set in that same cycle. Each application's threshold comes from two running averages, which are exponential moving averages with a shift of 4. One tracks total end-to-end delay and the other tracks delay so far at this point. Both are fed by a sample port, and the threshold is placed part of the way from the so-far average toward the total average.

Both stream sides use valid/ready. A flit moves only on a cycle where valid and ready are both high. An upstream source must hold its flit steady until it is taken. Downstream back-pressure stalls the held flit. During a stall every header bit stays steady except the age field and the priority bit, which keep advancing.

Top module: `age_lateness_tagger`

## Requirements
- R1: `in_ready` is high when the slot is empty or `out_ready` is high. `out_valid` rises on the cycle after an accepted input, and the held flit leaves on a cycle with `out_valid` and `out_ready` both high.
- R2: The age field is bits [11:0]. On acceptance it becomes the incoming age plus one increment. Every further cycle the flit is held without leaving adds one more increment.
- R3: The increment is `freq_mult` clipped into the range 1 to 8: a value of 0 adds 1, and values above 8 add 8.
- R4: The age saturates at 4095 and never wraps.
- R5: All header bits other than the age field and the priority bit (bit 12) pass through unchanged, and they stay stable while the output is stalled.
- R6: A response message (bit 13 set) is one whose age is strictly greater than the threshold of its application (bits 16:14). Such a flit is presented with the priority bit set. An age equal to the threshold is not late.
- R7: A priority bit that arrives set is never cleared. Once a held flit has been shown as late, it stays marked until it leaves. A non-response flit keeps its incoming priority bit.
- R8: The threshold is the so-far average plus half of the gap between the total average and the so-far average, where a negative gap counts as zero. Both averages reset to 256.
- R9: A sample with `smp_valid` high moves both averages of application `smp_app` by (sample - average) >>> 4, using arithmetic shift, and leaves every other application unchanged. The new values apply from the next cycle.
- R10: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local node clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freq_mult | input | 4 | Local frequency multiplier per cycle (clipped to 1..8) |
| in_valid | input | 1 | Upstream flit valid |
| in_ready | output | 1 | Slot can take a flit |
| in_flit | input | 128 | Incoming header flit |
| out_valid | output | 1 | Held flit presented for injection |
| out_ready | input | 1 | Network accepts the flit |
| out_flit | output | 128 | Header flit with updated age and priority |
| smp_valid | input | 1 | Delay sample strobe |
| smp_app | input | 3 | Application the sample belongs to |
| smp_total | input | 12 | Sampled total end-to-end delay |
| smp_sofar | input | 12 | Sampled so-far delay at this point |

## Verification
The bench targets several corner cases, and each one maps to a specific fault:
- **Age exactly equal to the threshold.** A design using `>=` would mark this flit too early.
- **Ages near 4095 under a long stall at the largest multiplier.** A design without saturation would wrap to small ages and drop the mark.
- **Multiplier values of 0 and above 8.** Without the clip, these would stall the age or overshoot it.
- **Flits that arrive already marked or are not responses.** These catch a priority bit that gets cleared or gets set on requests.
- **Samples that raise a threshold while a late flit is stalled.** A design with a mark that is not sticky would drop a priority it had already shown.

// File: rtl/age_tag_pkg.sv
package age_tag_pkg;
  localparam int FLIT_W   = 128;
  localparam int AGE_W    = 12;
  localparam int AGE_LSB  = 0;
  localparam int PRIO_BIT = 12;
  localparam int RESP_BIT = 13;
  localparam int APP_LSB  = 14;
  localparam int MULT_W   = 4;
  localparam int MULT_MAX = 8;
  localparam logic [AGE_W-1:0] AGE_SAT = {AGE_W{1'b1}};

  function automatic logic [AGE_W-1:0] sat_add(input logic [AGE_W-1:0] a,
                                               input logic [AGE_W-1:0] b);
    logic [AGE_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[AGE_W] ? AGE_SAT : s[AGE_W-1:0];
  endfunction
endpackage

// File: rtl/age_slot.sv
module age_slot
  import age_tag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AGE_W-1:0]  inc_i,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLIT_W-1:0] in_flit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLIT_W-1:0] flit_o,
  output logic [AGE_W-1:0]  age_o
);
  logic              full_q;
  logic [FLIT_W-1:0] flit_q;
  logic [AGE_W-1:0]  age_q;
  logic              fire_in, fire_out, stall;

  assign in_ready = !full_q || out_ready;
  assign fire_in  = in_valid && in_ready;
  assign fire_out = full_q && out_ready;
  assign stall    = full_q && !out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      flit_q <= '0;
      age_q  <= '0;
    end else if (fire_in) begin
      full_q <= 1'b1;
      flit_q <= in_flit;
      age_q  <= sat_add(in_flit[AGE_LSB +: AGE_W], inc_i);
    end else if (fire_out) begin
      full_q <= 1'b0;
    end else if (full_q) begin
      age_q <= sat_add(age_q, inc_i);
    end
  end

  assign out_valid = full_q;
  assign flit_o    = flit_q;
  assign age_o     = age_q;

  AST_AGE_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> age_o >= $past(age_o)); // R2
  AST_AGE_STEP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (age_o - $past(age_o)) <= AGE_W'(MULT_MAX)); // R3
  AST_PAYLOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(flit_o) && out_valid); // R5
endmodule

// File: rtl/lateness_table.sv
module lateness_table
  import age_tag_pkg::*;
#(
  parameter int APP_W     = 3,
  parameter int AVG_INIT  = 256,
  parameter int EMA_SHIFT = 4,
  parameter int GAP_SHIFT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [APP_W-1:0] smp_app,
  input  logic [AGE_W-1:0] smp_total,
  input  logic [AGE_W-1:0] smp_sofar,
  input  logic [APP_W-1:0] rd_app,
  output logic [AGE_W-1:0] thr_o
);
  localparam int APPS = 1 << APP_W;

  logic [AGE_W-1:0] tot_q [APPS];
  logic [AGE_W-1:0] sof_q [APPS];

  function automatic logic [AGE_W-1:0] ema(input logic [AGE_W-1:0] avg,
                                           input logic [AGE_W-1:0] s);
    logic signed [AGE_W+1:0] d;
    d = $signed({2'b00, s}) - $signed({2'b00, avg});
    d = d >>> EMA_SHIFT;
    d = d + $signed({2'b00, avg});
    return d[AGE_W-1:0];
  endfunction

  for (genvar g = 0; g < APPS; g++) begin : g_app
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tot_q[g] <= AGE_W'(AVG_INIT);
        sof_q[g] <= AGE_W'(AVG_INIT);
      end else if (smp_valid && smp_app == APP_W'(g)) begin
        tot_q[g] <= ema(tot_q[g], smp_total);
        sof_q[g] <= ema(sof_q[g], smp_sofar);
      end
    end
  end

  logic [AGE_W-1:0] tot_r, sof_r, gap;
  always_comb begin
    tot_r = tot_q[rd_app];
    sof_r = sof_q[rd_app];
    gap   = (tot_r > sof_r) ? (tot_r - sof_r) : '0;
    thr_o = sof_r + (gap >> GAP_SHIFT);
  end

  AST_THR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    thr_o >= sof_r); // R8
  AST_THR_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (tot_r >= sof_r) |-> thr_o <= tot_r); // R8
endmodule

// File: rtl/age_lateness_tagger.sv
module age_lateness_tagger
  import age_tag_pkg::*;
#(
  parameter int APP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MULT_W-1:0] freq_mult,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLIT_W-1:0] in_flit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLIT_W-1:0] out_flit,
  input  logic              smp_valid,
  input  logic [APP_W-1:0]  smp_app,
  input  logic [AGE_W-1:0]  smp_total,
  input  logic [AGE_W-1:0]  smp_sofar
);
  logic [AGE_W-1:0]  inc;
  logic [FLIT_W-1:0] held;
  logic [AGE_W-1:0]  age;
  logic [AGE_W-1:0]  thr;
  logic              late, mark_q;

  always_comb begin
    if (freq_mult == '0)                   inc = AGE_W'(1);
    else if (freq_mult > MULT_W'(MULT_MAX)) inc = AGE_W'(MULT_MAX);
    else                                   inc = AGE_W'(freq_mult);
  end

  age_slot u_slot (
    .clk(clk), .rst_n(rst_n), .inc_i(inc),
    .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .out_valid(out_valid), .out_ready(out_ready),
    .flit_o(held), .age_o(age)
  );

  lateness_table #(.APP_W(APP_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .smp_valid(smp_valid), .smp_app(smp_app),
    .smp_total(smp_total), .smp_sofar(smp_sofar),
    .rd_app(held[APP_LSB +: APP_W]), .thr_o(thr)
  );

  assign late = out_valid && held[RESP_BIT] && (age > thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       mark_q <= 1'b0;
    else if (in_valid && in_ready)    mark_q <= 1'b0;
    else if (out_valid && out_ready)  mark_q <= 1'b0;
    else if (late)                    mark_q <= 1'b1;
  end

  always_comb begin
    out_flit = held;
    out_flit[AGE_LSB +: AGE_W] = age;
    out_flit[PRIO_BIT] = held[PRIO_BIT] | mark_q | late;
  end

  AST_PRIO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && out_flit[PRIO_BIT] |=> out_flit[PRIO_BIT]); // R7
  AST_REQ_UNMARKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !held[RESP_BIT] |-> out_flit[PRIO_BIT] == held[PRIO_BIT]); // R7
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R1
  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R1
endmodule

// File: tb/age_lateness_tagger_bench.sv
`timescale 1ns/1ps
module age_lateness_tagger_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   freq_mult = 4'd1;
  logic         in_valid = 1'b0, out_ready = 1'b0, smp_valid = 1'b0;
  logic [127:0] in_flit = '0;
  logic [2:0]   smp_app = '0;
  logic [11:0]  smp_total = '0, smp_sofar = '0;
  logic         in_ready, out_valid;
  logic [127:0] out_flit;

  always #2.5 clk = ~clk;

  age_lateness_tagger u_age_lateness_tagger (
    .clk(clk), .rst_n(rst_n), .freq_mult(freq_mult),
    .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
    .smp_valid(smp_valid), .smp_app(smp_app),
    .smp_total(smp_total), .smp_sofar(smp_sofar)
  );

  int vectors = 0, errors = 0;
  bit done = 0;

  // reference state
  bit          m_full, m_mark;
  logic [127:0] m_flit;
  int          m_age;
  int          m_tot [8];
  int          m_sof [8];

  function automatic int clip_inc(input logic [3:0] f); // R3
    if (f == 0) return 1;
    if (f > 8)  return 8;
    return int'(f);
  endfunction
  function automatic int sat(input int a); // R4
    return (a > 4095) ? 4095 : a;
  endfunction
  function automatic int ema(input int avg, input int s); // R9
    int d;
    d = s - avg;
    return avg + (d >>> 4);
  endfunction
  function automatic int thr_of(input int app); // R8
    int gap;
    gap = m_tot[app] - m_sof[app];
    if (gap < 0) gap = 0;
    return m_sof[app] + (gap >> 1);
  endfunction
  function automatic bit late_now();
    return m_full && m_flit[13] && (m_age > thr_of(int'(m_flit[16:14])));
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_full = 0; m_mark = 0; m_flit = '0; m_age = 0;
      for (int a = 0; a < 8; a++) begin m_tot[a] = 256; m_sof[a] = 256; end
    end else begin
      bit fin, fout, lt;
      int inc;
      inc  = clip_inc(freq_mult);
      lt   = late_now();
      fout = m_full && out_ready;
      fin  = in_valid && (!m_full || out_ready);
      if (fin) begin
        m_full = 1; m_mark = 0; m_flit = in_flit;
        m_age  = sat(int'(in_flit[11:0]) + inc);
      end else if (fout) begin
        m_full = 0; m_mark = 0;
      end else if (m_full) begin
        if (lt) m_mark = 1;
        m_age = sat(m_age + inc);
      end
      if (smp_valid) begin
        m_tot[smp_app] = ema(m_tot[smp_app], int'(smp_total));
        m_sof[smp_app] = ema(m_sof[smp_app], int'(smp_sofar));
      end
    end
  end

  function automatic logic [127:0] mk(input int age, input bit prio, input bit resp,
                                      input int app);
    logic [127:0] f;
    f = {$urandom, $urandom, $urandom, $urandom};
    f[11:0] = age[11:0]; f[12] = prio; f[13] = resp; f[16:14] = app[2:0];
    return f;
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 out_valid after reset", {127'd0, out_valid}, 128'd0);
    check("R10 in_ready after reset", {127'd0, in_ready}, 128'd1);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      if (out_valid !== m_full) check("R1 out_valid", {127'd0, out_valid}, {127'd0, m_full});
      else vectors++;
      if (m_full) begin
        logic [127:0] e;
        bit ep;
        e = m_flit;
        e[11:0] = m_age[11:0];
        ep = m_flit[12] | m_mark | late_now();
        e[12] = ep;
        check("R5 payload", {out_flit[127:13], 1'b0, 12'd0}, {e[127:13], 1'b0, 12'd0});
        check((m_age == 4095) ? "R4 age saturation" : "R2/R3 age field",
              {116'd0, out_flit[11:0]}, {116'd0, e[11:0]});
        check((m_flit[13] && !m_flit[12]) ? "R6 priority mark" : "R7 priority keep",
              {127'd0, out_flit[12]}, {127'd0, ep});
      end
      // stimulus: directed first, then random
      smp_valid = 1'b0;
      if (cyc < 40) begin
        out_ready = 1'b1; in_valid = 1'b0; freq_mult = 4'd1;
        case (cyc)
          0: begin in_valid = 1; in_flit = mk(255, 0, 1, 0); end   // R6 equal -> not late
          1: begin in_valid = 1; in_flit = mk(256, 0, 1, 0); end   // R6 one above
          2: begin in_valid = 1; in_flit = mk(4090, 0, 1, 1); freq_mult = 4'd15; end
          3,4,5,6: begin out_ready = 0; freq_mult = 4'd15; end     // R3 R4
          7: begin in_valid = 1; in_flit = mk(10, 0, 1, 2); freq_mult = 4'd0; end
          8,9: begin out_ready = 0; freq_mult = 4'd0; end          // R3 zero
          10: begin in_valid = 1; in_flit = mk(4000, 0, 0, 3); end // R7 request
          11: begin in_valid = 1; in_flit = mk(3, 1, 1, 4); end    // R7 preset
          12: begin in_valid = 1; in_flit = mk(300, 0, 1, 5); end
          13: out_ready = 0;
          14: begin out_ready = 0; smp_valid = 1; smp_app = 3'd5;    // R9 raise thr
                    smp_total = 12'd4095; smp_sofar = 12'd4095; end
          15: out_ready = 0;                                       // R7 sticky mark
          default: ;
        endcase
      end else begin
        in_valid  = ($urandom % 4) != 0;
        out_ready = ($urandom % 5) < 3;
        freq_mult = 4'($urandom % 16);
        in_flit   = mk(($urandom % 8 == 0) ? 3900 + int'($urandom % 196)
                                           : int'($urandom % 700),
                       ($urandom % 4) == 0, ($urandom % 3) != 0, int'($urandom % 8));
        if ($urandom % 3 == 0) begin
          smp_valid = 1'b1;
          smp_app   = 3'($urandom % 8);
          smp_total = 12'($urandom % 1200);
          smp_sofar = 12'($urandom % 800);
        end
      end
      #1;
      check("R1 in_ready", {127'd0, in_ready}, {127'd0, (!m_full || out_ready)});
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule